// File: doc/BRIEF.md
# Supervisor Operating Mode Controller

This block sequences a power-supervisor device through its operating modes. It reacts to a millisecond tick, to command strobes already decoded from the serial host interface, to a supply-low flag, to a wake event and to a debug-detect flag. From these it decides the current mode and drives the active-low reset pin, the battery-fail flag, the write enable for the registers that may be set only during initialisation, and the enable for the external regulator pass device.

There are eight modes. After power-up the device passes through a short init-reset into an init window, where the host configures it and refreshes the watchdog. From normal operation the host may move to low-power states, to an extended-watchdog flash mode, or back to reset or init. Reset and init, and flash, can be entered only by secured commands. A watchdog fault or a supply-low event sends the device to reset, which always leads into normal-request. A refresh must then arrive within a window, or the device falls back into reset. The watchdog period counter, the serial shifter and the analog detectors sit outside the block. Their results arrive here as strobes.

Mode transitions are named as follows. PowerUp enters INIT_RST. RstDone goes INIT_RST→INIT. InitRefresh goes INIT→NORMAL. InitTimeout goes INIT→INIT_RST. ResetDone goes RESET→NREQ. NreqRefresh goes NREQ→NORMAL. NreqTimeout goes NREQ→RESET. WdFault and VddLow go to RESET. SecReset, SecInit and SecFlash leave NORMAL. LpEnter goes NORMAL→LP_ON or LP_OFF. FlashExit goes FLASH→NORMAL. Wake goes LP_ON or LP_OFF→NREQ.

Top module: `svmc_mode_ctrl`

## Requirements
- R1: After power-on reset the mode is 0 (init-reset), `rst_pin_n` is 0 and `batfail` is 1. After RST_MS ticks (default 1) the mode becomes 1 (init) on the following clock.
- R2: In init (1), a `wd_refresh` strobe moves the mode to 4 (normal) on the next clock.
- R3: In init with debug inactive, the mode returns to 0 if WIN_MS ticks (default 256) pass without a refresh. After 255 ticks it is still 1. It then goes back to 1 after RST_MS more ticks.
- R4: `init_wr_en` is high only while the mode is 1 and a register write (`reg_wr`) targets the init-only class (`reg_wr_init`=1). A write to any other class never raises it.
- R5: Once init has been left, the mode reaches 1 again only through a secured command with target 1 issued in normal (4). A secured command outside normal is ignored.
- R6: A `wd_fault` strobe in normal-request, normal, flash or low-power-on sends the mode to 2 (reset) for RST_MS ticks. `vdd_low` in those modes sends it to 2 for `cfg_vdd_rst_ms` ticks (the value must be at least 1). `vdd_low` takes priority over `wd_fault`, and both take priority over commands.
- R7: Reset (2) always moves to normal-request (3) when its count ends. In 3, a refresh moves to 4, and WIN_MS ticks without one move to 2.
- R8: In normal, a plain command with target 6 or 7 enters low-power-on (6) or low-power-off (7). A `wake` strobe in either moves to 3 with a window of `cfg_wake_win_ms` ticks. `wd_fault` has no effect in 7.
- R9: In normal, a secured command with target 2, 1 or 5 enters that mode. Any other secured target, and any plain target other than 6 or 7, leaves the mode at 4. Command targets use the mode codes.
- R10: In flash (5), a plain command with target 4 returns to normal. Other plain targets are ignored.
- R11: `reg_pass_en` is 1 only in normal (4) and flash (5).
- R12: `dbg_active` takes the value of `dbg_detect` during init-reset. It clears when `dbg_detect` drops or on a `dbg_exit` strobe. While it is set, the init window, the normal-request window and `wd_fault` cause no transition. `vdd_low` still does.
- R13: `batfail` is set only by power-on reset and cleared by a `batfail_clr` strobe. Later entries into init-reset do not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| wd_refresh | input | 1 | Valid watchdog refresh command strobe |
| wd_fault | input | 1 | Watchdog expiry or bad refresh strobe |
| vdd_low | input | 1 | Supply-low event |
| wake | input | 1 | Wake-up event from a low-power mode |
| cmd_secure | input | 1 | Secured mode-change command strobe |
| cmd_plain | input | 1 | Ordinary mode-change command strobe |
| cmd_target | input | 3 | Target mode code of the command |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_init | input | 1 | Write targets the init-only register class |
| dbg_detect | input | 1 | Debug level detected on the debug pin |
| dbg_exit | input | 1 | Command strobe that leaves debug |
| batfail_clr | input | 1 | Clears the battery-fail flag |
| cfg_vdd_rst_ms | input | CW | Reset length in ticks after a supply-low event |
| cfg_wake_win_ms | input | CW | Normal-request window after a wake |
| rst_pin_n | output | 1 | Reset pin, active low |
| batfail | output | 1 | Battery-fail flag |
| mode | output | 3 | Current mode code |
| init_wr_en | output | 1 | Write enable for the init-only registers |
| reg_pass_en | output | 1 | External regulator pass enable |
| dbg_active | output | 1 | Debug currently suppresses timeouts |

## Verification
A wrong state register shows up on `mode` at the very next clock. Within the same cycle it also shows up on `rst_pin_n` and `reg_pass_en`, because both are decoded from the state. A wrong window or reset count stays hidden until its count ends. The bench therefore probes one tick before and one tick after each limit, which exposes an off-by-one as a mode that leaves one tick early or late. A wrong guard on a secured, plain or fault event appears as a mode code that moves when it should hold, or holds when it should move, one clock after the strobe.

// File: rtl/svmc_pkg.sv
package svmc_pkg;
    typedef enum logic [2:0] {
        MD_INIT_RST = 3'd0,
        MD_INIT     = 3'd1,
        MD_RESET    = 3'd2,
        MD_NREQ     = 3'd3,
        MD_NORMAL   = 3'd4,
        MD_FLASH    = 3'd5,
        MD_LP_ON    = 3'd6,
        MD_LP_OFF   = 3'd7
    } mode_e;
endpackage

// File: rtl/svmc_ms_timer.sv
module svmc_ms_timer #(
    parameter int TW     = 9,
    parameter int RST_MS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= TW'(RST_MS);
        else if (load)
            cnt <= load_val;
        else if (ms_tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/svmc_dbg_latch.sv
module svmc_dbg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic in_init_rst,
    input  logic dbg_detect,
    input  logic dbg_exit,
    output logic dbg_on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dbg_on <= 1'b0;
        else if (in_init_rst)
            dbg_on <= dbg_detect;
        else if (!dbg_detect || dbg_exit)
            dbg_on <= 1'b0;
    end
endmodule

// File: rtl/svmc_mode_fsm.sv
module svmc_mode_fsm
    import svmc_pkg::*;
#(
    parameter int RST_MS = 1,
    parameter int WIN_MS = 256,
    parameter int CW     = 8,
    parameter int TW     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_done,
    input  logic          dbg_on,
    input  logic          wd_refresh,
    input  logic          wd_fault,
    input  logic          vdd_low,
    input  logic          wake,
    input  logic          cmd_secure,
    input  logic          cmd_plain,
    input  logic [2:0]    cmd_target,
    input  logic [CW-1:0] cfg_vdd_rst_ms,
    input  logic [CW-1:0] cfg_wake_win_ms,
    output mode_e         state,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val
);
    localparam logic [TW-1:0] RST_LEN = TW'(RST_MS);
    localparam logic [TW-1:0] WIN_LEN = TW'(WIN_MS);

    mode_e nxt;
    logic  fault;

    assign fault = wd_fault && !dbg_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MD_INIT_RST;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = RST_LEN;
        unique case (state)
            MD_INIT_RST: if (ms_done) begin
                nxt = MD_INIT; tmr_load = 1'b1; tmr_val = WIN_LEN;
            end
            MD_INIT: begin
                if (wd_refresh) nxt = MD_NORMAL;
                else if (ms_done && !dbg_on) begin
                    nxt = MD_INIT_RST; tmr_load = 1'b1;
                end
            end
            MD_RESET: if (ms_done) begin
                nxt = MD_NREQ; tmr_load = 1'b1; tmr_val = WIN_LEN;
            end
            MD_NREQ: begin
                if (vdd_low) begin
                    nxt = MD_RESET; tmr_load = 1'b1; tmr_val = TW'(cfg_vdd_rst_ms);
                end else if (fault || (ms_done && !dbg_on && !wd_refresh)) begin
                    nxt = MD_RESET; tmr_load = 1'b1;
                end else if (wd_refresh) nxt = MD_NORMAL;
            end
            MD_NORMAL: begin
                if (vdd_low) begin
                    nxt = MD_RESET; tmr_load = 1'b1; tmr_val = TW'(cfg_vdd_rst_ms);
                end else if (fault) begin
                    nxt = MD_RESET; tmr_load = 1'b1;
                end else if (cmd_secure) begin
                    if (cmd_target == 3'(MD_RESET)) begin
                        nxt = MD_RESET; tmr_load = 1'b1;
                    end else if (cmd_target == 3'(MD_INIT)) begin
                        nxt = MD_INIT; tmr_load = 1'b1; tmr_val = WIN_LEN;
                    end else if (cmd_target == 3'(MD_FLASH))
                        nxt = MD_FLASH;
                end else if (cmd_plain) begin
                    if (cmd_target == 3'(MD_LP_ON))       nxt = MD_LP_ON;
                    else if (cmd_target == 3'(MD_LP_OFF)) nxt = MD_LP_OFF;
                end
            end
            MD_FLASH: begin
                if (vdd_low) begin
                    nxt = MD_RESET; tmr_load = 1'b1; tmr_val = TW'(cfg_vdd_rst_ms);
                end else if (fault) begin
                    nxt = MD_RESET; tmr_load = 1'b1;
                end else if (cmd_plain && cmd_target == 3'(MD_NORMAL))
                    nxt = MD_NORMAL;
            end
            MD_LP_ON: begin
                if (vdd_low) begin
                    nxt = MD_RESET; tmr_load = 1'b1; tmr_val = TW'(cfg_vdd_rst_ms);
                end else if (fault) begin
                    nxt = MD_RESET; tmr_load = 1'b1;
                end else if (wake) begin
                    nxt = MD_NREQ; tmr_load = 1'b1; tmr_val = TW'(cfg_wake_win_ms);
                end
            end
            MD_LP_OFF: if (wake) begin
                nxt = MD_NREQ; tmr_load = 1'b1; tmr_val = TW'(cfg_wake_win_ms);
            end
        endcase
    end
endmodule

// File: rtl/svmc_mode_ctrl.sv
module svmc_mode_ctrl
    import svmc_pkg::*;
#(
    parameter int RST_MS = 1,
    parameter int WIN_MS = 256,
    parameter int CW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          wd_refresh,
    input  logic          wd_fault,
    input  logic          vdd_low,
    input  logic          wake,
    input  logic          cmd_secure,
    input  logic          cmd_plain,
    input  logic [2:0]    cmd_target,
    input  logic          reg_wr,
    input  logic          reg_wr_init,
    input  logic          dbg_detect,
    input  logic          dbg_exit,
    input  logic          batfail_clr,
    input  logic [CW-1:0] cfg_vdd_rst_ms,
    input  logic [CW-1:0] cfg_wake_win_ms,
    output logic          rst_pin_n,
    output logic          batfail,
    output logic [2:0]    mode,
    output logic          init_wr_en,
    output logic          reg_pass_en,
    output logic          dbg_active
);
    localparam int WIN_W = $clog2(WIN_MS + 1);
    localparam int TW    = (WIN_W > CW) ? WIN_W : CW;

    mode_e         state;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;

    svmc_ms_timer #(.TW(TW), .RST_MS(RST_MS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    svmc_dbg_latch u_dbg (
        .clk(clk), .rst_n(rst_n), .in_init_rst(state == MD_INIT_RST),
        .dbg_detect(dbg_detect), .dbg_exit(dbg_exit), .dbg_on(dbg_active)
    );

    svmc_mode_fsm #(.RST_MS(RST_MS), .WIN_MS(WIN_MS), .CW(CW), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ms_done(tmr_done), .dbg_on(dbg_active),
        .wd_refresh(wd_refresh), .wd_fault(wd_fault), .vdd_low(vdd_low),
        .wake(wake), .cmd_secure(cmd_secure), .cmd_plain(cmd_plain),
        .cmd_target(cmd_target), .cfg_vdd_rst_ms(cfg_vdd_rst_ms),
        .cfg_wake_win_ms(cfg_wake_win_ms), .state(state),
        .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           batfail <= 1'b1;
        else if (batfail_clr) batfail <= 1'b0;
    end

    always_comb begin
        mode        = state;
        rst_pin_n   = !(state == MD_INIT_RST || state == MD_RESET);
        reg_pass_en = (state == MD_NORMAL || state == MD_FLASH);
        init_wr_en  = reg_wr && reg_wr_init && (state == MD_INIT);
    end
endmodule

// File: rtl/svmc_checks.sv
module svmc_checks
    import svmc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       reg_pass_en,
    input logic       init_wr_en,
    input logic       wd_refresh,
    input logic       vdd_low,
    input logic       cmd_secure,
    input logic       cmd_plain,
    input logic       dbg_active
);
    a_r1_initrst_exit: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MD_INIT_RST |=> (mode == MD_INIT_RST || mode == MD_INIT));

    a_r2_refresh_leaves_init: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_INIT && wd_refresh) |=> mode == MD_NORMAL);

    a_r4_init_lock: assert property (@(posedge clk) disable iff (!rst_n)
        mode != MD_INIT |-> !init_wr_en);

    a_r5_init_needs_secure: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_INIT && mode != MD_INIT_RST && !cmd_secure) |=> mode != MD_INIT);

    a_r6_vdd_low_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_low && (mode == MD_NREQ || mode == MD_NORMAL || mode == MD_FLASH
                     || mode == MD_LP_ON)) |=> mode == MD_RESET);

    a_r7_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MD_RESET |=> (mode == MD_RESET || mode == MD_NREQ));

    a_r11_pass_off: assert property (@(posedge clk) disable iff (!rst_n)
        reg_pass_en |-> (mode == MD_NORMAL || mode == MD_FLASH));

    a_r12_debug_holds_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && mode == MD_NORMAL && !vdd_low && !cmd_secure && !cmd_plain)
        |=> mode == MD_NORMAL);
endmodule

bind svmc_mode_ctrl svmc_checks u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_pass_en(reg_pass_en),
    .init_wr_en(init_wr_en), .wd_refresh(wd_refresh), .vdd_low(vdd_low),
    .cmd_secure(cmd_secure), .cmd_plain(cmd_plain), .dbg_active(dbg_active)
);

// File: tb/tb_svmc_mode_ctrl.sv
module tb_svmc_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, ms_tick, wd_refresh, wd_fault, vdd_low, wake;
    logic cmd_secure, cmd_plain, reg_wr, reg_wr_init, dbg_detect, dbg_exit, batfail_clr;
    logic [2:0] cmd_target;
    logic [7:0] cfg_vdd_rst_ms, cfg_wake_win_ms;
    logic rst_pin_n, batfail, init_wr_en, reg_pass_en, dbg_active;
    logic [2:0] mode;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svmc_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wd_refresh(wd_refresh),
        .wd_fault(wd_fault), .vdd_low(vdd_low), .wake(wake),
        .cmd_secure(cmd_secure), .cmd_plain(cmd_plain), .cmd_target(cmd_target),
        .reg_wr(reg_wr), .reg_wr_init(reg_wr_init), .dbg_detect(dbg_detect),
        .dbg_exit(dbg_exit), .batfail_clr(batfail_clr),
        .cfg_vdd_rst_ms(cfg_vdd_rst_ms), .cfg_wake_win_ms(cfg_wake_win_ms),
        .rst_pin_n(rst_pin_n), .batfail(batfail), .mode(mode),
        .init_wr_en(init_wr_en), .reg_pass_en(reg_pass_en), .dbg_active(dbg_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            ms_tick = 1'b1; step();
            ms_tick = 1'b0; step();
        end
    endtask

    task automatic refresh();
        wd_refresh = 1'b1; step(); wd_refresh = 1'b0;
    endtask

    task automatic fault();
        wd_fault = 1'b1; step(); wd_fault = 1'b0;
    endtask

    task automatic do_wake();
        wake = 1'b1; step(); wake = 1'b0;
    endtask

    task automatic cmd(input bit sec, input int tgt);
        cmd_target = 3'(tgt);
        if (sec) cmd_secure = 1'b1; else cmd_plain = 1'b1;
        step();
        cmd_secure = 1'b0; cmd_plain = 1'b0;
    endtask

    task automatic power_up(input bit dbg);
        dbg_detect = dbg;
        rst_n = 1'b0; step(2); rst_n = 1'b1; step();
    endtask

    function automatic int exp_from_normal(input bit sec, input int tgt);
        if (sec) return (tgt == 2 || tgt == 1 || tgt == 5) ? tgt : 4;
        return (tgt == 6 || tgt == 7) ? tgt : 4;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        {ms_tick, wd_refresh, wd_fault, vdd_low, wake, cmd_secure, cmd_plain} = '0;
        {reg_wr, reg_wr_init, dbg_exit, batfail_clr} = '0;
        cmd_target = 3'd0; cfg_vdd_rst_ms = 8'd5; cfg_wake_win_ms = 8'd10;
        seed_dummy = $urandom(1234);

        power_up(1'b0);
        chk("R1 mode", mode, 0); chk("R1 rst_pin_n", rst_pin_n, 0);
        chk("R1 batfail", batfail, 1); chk("R11 pass in init-reset", reg_pass_en, 0);
        tick(1); step();
        chk("R1 to init", mode, 1);
        reg_wr = 1; reg_wr_init = 1; #1;
        chk("R4 init write", init_wr_en, 1);
        reg_wr_init = 0; #1;
        chk("R4 other class", init_wr_en, 0);
        reg_wr = 0;

        tick(255); step();
        chk("R3 before window", mode, 1);
        tick(1); step();
        chk("R3 timeout", mode, 0); chk("R3 rst pin", rst_pin_n, 0);
        tick(1); step();
        chk("R3 re-init", mode, 1);

        refresh();
        chk("R2 refresh", mode, 4); chk("R11 pass normal", reg_pass_en, 1);
        chk("R1 pin released", rst_pin_n, 1);
        reg_wr = 1; reg_wr_init = 1; #1;
        chk("R4 locked in normal", init_wr_en, 0);
        reg_wr = 0; reg_wr_init = 0;
        chk("R13 batfail held", batfail, 1);
        batfail_clr = 1; step(); batfail_clr = 0;
        chk("R13 cleared", batfail, 0);

        fault();
        chk("R6 wd fault", mode, 2); chk("R6 pin low", rst_pin_n, 0);
        tick(1); step();
        chk("R7 to nreq", mode, 3); chk("R11 pass nreq", reg_pass_en, 0);
        tick(255); step();
        chk("R7 nreq before window", mode, 3);
        tick(1); step();
        chk("R7 nreq timeout", mode, 2);
        tick(1); step(); refresh();
        chk("R7 nreq refresh", mode, 4);

        vdd_low = 1; step(); vdd_low = 0;
        chk("R6 vdd low", mode, 2);
        tick(4); step();
        chk("R6 vdd length hold", mode, 2);
        tick(1); step();
        chk("R6 vdd length end", mode, 3);
        refresh();

        vdd_low = 1; wd_fault = 1; cmd_target = 3'd5; cmd_secure = 1; step();
        vdd_low = 0; wd_fault = 0; cmd_secure = 0;
        chk("R6 priority", mode, 2);
        tick(4); step();
        chk("R6 priority uses vdd length", mode, 2);
        tick(1); step(); refresh();

        cmd(0, 6);
        chk("R8 lp on", mode, 6);
        do_wake();
        chk("R8 wake", mode, 3);
        tick(9); step();
        chk("R8 wake window hold", mode, 3);
        tick(1); step();
        chk("R8 wake window end", mode, 2);
        tick(1); step(); refresh();
        cmd(0, 7);
        chk("R8 lp off", mode, 7);
        fault();
        chk("R8 fault ignored lp off", mode, 7);
        do_wake(); refresh();
        chk("R8 back to normal", mode, 4);

        cmd(1, 5);
        chk("R9 secure flash", mode, 5); chk("R11 pass flash", reg_pass_en, 1);
        cmd(0, 6);
        chk("R10 flash ignores", mode, 5);
        cmd(0, 4);
        chk("R10 flash exit", mode, 4);

        fault(); tick(1); step();
        cmd(1, 1);
        chk("R5 secure ignored in nreq", mode, 3);
        refresh();
        cmd(0, 1);
        chk("R9 plain init ignored", mode, 4);
        cmd(1, 1);
        chk("R5 secure init", mode, 1);
        tick(256); step(); tick(1); step();
        chk("R13 not set again", batfail, 0);
        refresh();

        for (int i = 0; i < 40; i++) begin
            bit sec = 1'($urandom % 2);
            int tgt = int'($urandom % 8);
            int e = exp_from_normal(sec, tgt);
            cmd(sec, tgt);
            chk("R9 random command", mode, e);
            case (e)
                1: refresh();
                2: begin tick(1); step(); refresh(); end
                5: cmd(0, 4);
                6, 7: begin do_wake(); refresh(); end
                default: ;
            endcase
            chk("R9 random return", mode, 4);
        end

        power_up(1'b1);
        tick(1); step();
        chk("R12 debug captured", dbg_active, 1);
        tick(300); step();
        chk("R12 init window off", mode, 1);
        refresh(); fault();
        chk("R12 fault suppressed", mode, 4);
        dbg_exit = 1; step(); dbg_exit = 0;
        chk("R12 exit cmd", dbg_active, 0);
        fault();
        chk("R12 fault after exit", mode, 2);

        power_up(1'b1);
        tick(1); step(); tick(300); step();
        dbg_detect = 0; step(2);
        chk("R12 flag drop ends debug", mode, 0);
        chk("R13 power-on sets", batfail, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule